// File: doc/BRIEF.md
# Serial Port Data Buffer and Status Flags

This block sits between a host bus and the two serializers of an asynchronous serial port. Both directions share one data address. A host write to that address fills a one-byte transmit holding register. A host read from it returns the oldest byte of a two-entry receive queue, and every read access removes that byte. When the transmitter is enabled and its shifter is idle, the held byte moves into the shifter, and the host may then write the next byte.

An eight-bit status byte carries the flags the host polls or takes interrupts on: receive ready, transmit done, holding empty, the framing and parity error bits of the byte at the head of the receive queue, receive overrun, and two plain control bits (double speed and multiprocessor mode). Characters of 5 to 8 bits are supported. The transmit shifter included here is a minimal stub that sends a start bit, the data bits LSB first and one stop bit, each lasting `BIT_CYCLES` clocks. The receive side is fed by an external deserializer through a one-cycle valid strobe.

Top module: `sio_buffer_core`

## Requirements
- R1: A `data_wr` pulse stores `wr_byte` into the transmit holding register. `rd_byte` shows the data of the receive queue head, or 0 when the queue is empty.
- R2: `char_width` selects the character length: 0=5, 1=6, 2=7 or 3=8 bits. Written bits above that length are not transmitted, and received bits above it read back as 0. The width is taken when a byte is written or received.
- R3: Holding empty (status bit 5) is 1 after reset. A `data_wr` is dropped when the bit is 0. An accepted write clears the bit on the next cycle, and the bit sets again on the cycle after the byte moves into the shifter.
- R4: When `tx_en` is 1, the register holds a byte and the shifter is idle, the byte moves into the shifter. The `txd` line then sends a 0 start bit, the data bits LSB first and a 1 stop bit, each for `BIT_CYCLES` cycles. The line is 1 when idle. With `tx_en` at 0 the byte stays held.
- R5: The receive queue holds two entries. Each `data_rd` pulse removes the head entry, and a read of an empty queue changes nothing.
- R6: Receive ready (status bit 7) is 1 exactly while the queue holds unread data.
- R7: While `rx_en` is 0, the queue is emptied, receive ready and overrun read 0, and incoming characters are discarded.
- R8: Transmit done (status bit 6) sets on the cycle after the last stop-bit cycle, provided the holding register is empty and no `data_wr` arrives in that last cycle. It clears on `txc_ack`, or on a `ctl_wr` with bit 6 set. A set in the same cycle as a clear wins.
- R9: The status byte, from bit 7 down to bit 0, is: receive ready, transmit done, holding empty, framing error, overrun, parity error, double speed, multiprocessor mode. It resets to 0x20. A `ctl_wr` writes bits 1 and 0, and does not change bits 7, 5, 4, 3 or 2.
- R10: Overrun (bit 3) sets when a character arrives while the queue is full and no read happens in that cycle. That character is lost. The bit clears on the next data read.
- R11: Framing error (bit 4) and parity error (bit 2) show the flags stored with the queue head entry, and read 0 when the queue is empty.
- R12: Each of `irq_rx_ready`, `irq_hold_empty` and `irq_tx_done` is its flag ANDed with its enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_width | input | 2 | Character length code (0=5 to 3=8 bits) |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low empties the queue |
| data_wr | input | 1 | Write strobe to the data address |
| data_rd | input | 1 | Read strobe to the data address (removes one entry) |
| wr_byte | input | 8 | Write data for the data address |
| rd_byte | output | 8 | Receive queue head data |
| ctl_wr | input | 1 | Write strobe to the status byte |
| ctl_wbyte | input | 8 | Write data for the status byte |
| ctl_byte | output | 8 | Status byte |
| rx_valid | input | 1 | Deserializer delivers a character |
| rx_char | input | 8 | Received character |
| rx_frame_err | input | 1 | Framing error of the delivered character |
| rx_parity_err | input | 1 | Parity error of the delivered character |
| txd | output | 1 | Serial transmit line |
| ie_rx_ready | input | 1 | Enable for the receive-ready interrupt |
| ie_hold_empty | input | 1 | Enable for the holding-empty interrupt |
| ie_tx_done | input | 1 | Enable for the transmit-done interrupt |
| txc_ack | input | 1 | Transmit-done interrupt acknowledge |
| irq_rx_ready | output | 1 | Receive-ready interrupt request |
| irq_hold_empty | output | 1 | Holding-empty interrupt request |
| irq_tx_done | output | 1 | Transmit-done interrupt request |

## Verification
The bound checker watches five cause-and-effect rules on every cycle. An accepted write always empties the holding-empty flag. Receive ready can only rise after a delivered character. A disabled receiver always leaves receive ready low. Transmit done never rises while a byte is held. Overrun only rises after a character arrives with no read in the same cycle. The exact frame waveform on `txd`, the masking of the upper bits for short characters, and which byte survives an overrun depend on data and history, so only the bench's behavioural model can show them. That model is compared with every output on every cycle, across scenarios for back-to-back writes, disabled transmit, short characters, a full queue, a read and a push in the same cycle, a flush, and the clear paths of transmit done.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        CW5 = 2'd0,
        CW6 = 2'd1,
        CW7 = 2'd2,
        CW8 = 2'd3
    } char_w_e;

    typedef struct packed {
        logic [7:0] data;
        logic       ferr;
        logic       perr;
    } rx_ent_t;

    localparam int ST_RX_READY = 7;
    localparam int ST_TX_DONE  = 6;
    localparam int ST_HOLD_MT  = 5;
    localparam int ST_FRAME    = 4;
    localparam int ST_OVERRUN  = 3;
    localparam int ST_PARITY   = 2;
    localparam int ST_DBL      = 1;
    localparam int ST_MPM      = 0;

    function automatic logic [3:0] char_len(char_w_e w);
        return 4'd5 + {2'b00, w};
    endfunction

    function automatic logic [7:0] char_mask(char_w_e w);
        logic [7:0] m;
        m = 8'hFF >> (4'd8 - char_len(w));
        return m;
    endfunction

endpackage

// File: rtl/sio_tx_hold.sv
module sio_tx_hold
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wbyte,
    input  char_w_e    width,
    input  logic       take,
    output logic       full,
    output logic [7:0] held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= 8'h00;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr && !full) begin
            full <= 1'b1;
            held <= wbyte & char_mask(width);
        end
    end
endmodule

// File: rtl/sio_tx_shift.sv
module sio_tx_shift
    import sio_pkg::*;
#(
    parameter int BIT_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  char_w_e    width,
    output logic       busy,
    output logic       done,
    output logic       txd
);
    localparam int TW = $clog2(BIT_CYCLES + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(BIT_CYCLES - 1);

    logic [TW-1:0] tick;
    logic [3:0]    pos;
    logic [3:0]    last_pos;
    logic [7:0]    sh;
    logic [7:0]    shifted;
    char_w_e       w_q;

    assign last_pos = char_len(w_q) + 4'd1;
    assign done     = busy && (tick == TICK_LAST) && (pos == last_pos);
    assign shifted  = sh >> (pos - 4'd1);

    always_comb begin
        if (!busy)                    txd = 1'b1;
        else if (pos == 4'd0)         txd = 1'b0;
        else if (pos <= char_len(w_q)) txd = shifted[0];
        else                          txd = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            tick <= '0;
            pos  <= 4'd0;
            sh   <= 8'h00;
            w_q  <= CW8;
        end else if (load) begin
            busy <= 1'b1;
            tick <= '0;
            pos  <= 4'd0;
            sh   <= load_byte;
            w_q  <= width;
        end else if (busy) begin
            if (tick == TICK_LAST) begin
                tick <= '0;
                if (pos == last_pos) busy <= 1'b0;
                else                 pos  <= pos + 4'd1;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo
    import sio_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  logic    push,
    input  rx_ent_t push_ent,
    input  logic    pop,
    output logic    nonempty,
    output rx_ent_t head,
    output logic    overrun
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    rx_ent_t       mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_pop, do_push, lost;

    assign nonempty = (count != '0);
    assign head     = nonempty ? mem[rd_ptr] : '0;
    assign do_pop   = pop && nonempty;
    assign lost     = push && (count == FULL_CNT) && !do_pop;
    assign do_push  = push && !lost;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push) wr_ptr <= bump(wr_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (lost)        overrun <= 1'b1;
            else if (do_pop) overrun <= 1'b0;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                  mem[i] <= '0;
            else if (do_push && wr_ptr == PW'(i))     mem[i] <= push_ent;
        end
    end
endmodule

// File: rtl/sio_buffer_core.sv
module sio_buffer_core
    import sio_pkg::*;
#(
    parameter int BIT_CYCLES = 4,
    parameter int RX_DEPTH   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] char_width,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wr_byte,
    output logic [7:0] rd_byte,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wbyte,
    output logic [7:0] ctl_byte,
    input  logic       rx_valid,
    input  logic [7:0] rx_char,
    input  logic       rx_frame_err,
    input  logic       rx_parity_err,
    output logic       txd,
    input  logic       ie_rx_ready,
    input  logic       ie_hold_empty,
    input  logic       ie_tx_done,
    input  logic       txc_ack,
    output logic       irq_rx_ready,
    output logic       irq_hold_empty,
    output logic       irq_tx_done
);
    char_w_e    width;
    logic       hold_full, sh_busy, sh_done, load;
    logic [7:0] held;
    logic       tx_done_q, dbl_q, mpm_q;
    logic       rx_nonempty, rx_overrun;
    rx_ent_t    rx_head, rx_in;

    assign width = char_w_e'(char_width);
    assign load  = tx_en && hold_full && !sh_busy;

    sio_tx_hold u_hold (
        .clk(clk), .rst(rst), .wr(data_wr), .wbyte(wr_byte), .width(width),
        .take(load), .full(hold_full), .held(held)
    );

    sio_tx_shift #(.BIT_CYCLES(BIT_CYCLES)) u_shift (
        .clk(clk), .rst(rst), .load(load), .load_byte(held), .width(width),
        .busy(sh_busy), .done(sh_done), .txd(txd)
    );

    assign rx_in.data = rx_char & char_mask(width);
    assign rx_in.ferr = rx_frame_err;
    assign rx_in.perr = rx_parity_err;

    sio_rx_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(!rx_en), .push(rx_valid), .push_ent(rx_in),
        .pop(data_rd), .nonempty(rx_nonempty), .head(rx_head), .overrun(rx_overrun)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_done_q <= 1'b0;
            dbl_q     <= 1'b0;
            mpm_q     <= 1'b0;
        end else begin
            if (sh_done && !hold_full && !data_wr)
                tx_done_q <= 1'b1;
            else if (txc_ack || (ctl_wr && ctl_wbyte[ST_TX_DONE]))
                tx_done_q <= 1'b0;
            if (ctl_wr) begin
                dbl_q <= ctl_wbyte[ST_DBL];
                mpm_q <= ctl_wbyte[ST_MPM];
            end
        end
    end

    always_comb begin
        ctl_byte              = 8'h00;
        ctl_byte[ST_RX_READY] = rx_nonempty;
        ctl_byte[ST_TX_DONE]  = tx_done_q;
        ctl_byte[ST_HOLD_MT]  = !hold_full;
        ctl_byte[ST_FRAME]    = rx_head.ferr;
        ctl_byte[ST_OVERRUN]  = rx_overrun;
        ctl_byte[ST_PARITY]   = rx_head.perr;
        ctl_byte[ST_DBL]      = dbl_q;
        ctl_byte[ST_MPM]      = mpm_q;
    end

    assign rd_byte        = rx_head.data;
    assign irq_rx_ready   = rx_nonempty && ie_rx_ready;
    assign irq_hold_empty = !hold_full && ie_hold_empty;
    assign irq_tx_done    = tx_done_q && ie_tx_done;
endmodule

// File: rtl/sio_buffer_core_chk.sv
module sio_buffer_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_en,
    input logic       rx_valid,
    input logic       data_wr,
    input logic       data_rd,
    input logic [7:0] ctl_byte
);
    a_r3_write_fills_hold: assert property (@(posedge clk) disable iff (rst)
        (data_wr && ctl_byte[5]) |=> !ctl_byte[5]);

    a_r6_ready_needs_char: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_byte[7]) |-> $past(rx_valid && rx_en));

    a_r7_flush_clears_ready: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !ctl_byte[7]);

    a_r8_done_needs_empty_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_byte[6]) |-> ctl_byte[5]);

    a_r10_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_byte[3]) |-> $past(rx_valid && rx_en && !data_rd));
endmodule

bind sio_buffer_core sio_buffer_core_chk chk_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_valid(rx_valid),
    .data_wr(data_wr), .data_rd(data_rd), .ctl_byte(ctl_byte)
);

// File: tb/sio_buffer_core_tb_top.sv
module sio_buffer_core_tb_top;
    localparam int BC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] char_width = 2'd3;
    logic       tx_en = 1'b0, rx_en = 1'b0;
    logic       data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [7:0] rd_byte;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wbyte = 8'h00;
    logic [7:0] ctl_byte;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic       rx_frame_err = 1'b0, rx_parity_err = 1'b0;
    logic       txd;
    logic       ie_rx_ready = 1'b0, ie_hold_empty = 1'b0, ie_tx_done = 1'b0;
    logic       txc_ack = 1'b0;
    logic       irq_rx_ready, irq_hold_empty, irq_tx_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10ns clk = ~clk;

    sio_buffer_core #(.BIT_CYCLES(BC), .RX_DEPTH(2)) dut_i (.*);

    // behavioural reference model
    bit         m_hold_full, m_busy, m_txc, m_dbl, m_mpm, m_dor;
    logic [7:0] m_hold;
    logic [7:0] m_sh;
    int         m_n, m_tick, m_idx;
    logic [9:0] m_q[$];

    function automatic int len_of(logic [1:0] w);
        return 5 + int'(w);
    endfunction

    function automatic logic [7:0] mask_of(logic [1:0] w);
        logic [7:0] m = 8'h00;
        for (int i = 0; i < len_of(w); i++) m[i] = 1'b1;
        return m;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_hold_full = 0; m_busy = 0; m_txc = 0; m_dbl = 0; m_mpm = 0; m_dor = 0;
            m_hold = 0; m_sh = 0; m_n = 8; m_tick = 0; m_idx = 0;
            m_q.delete();
        end else begin
            bit done_now, load_now, pop_now, lost_now;
            done_now = m_busy && m_tick == BC - 1 && m_idx == m_n + 1;
            load_now = tx_en && m_hold_full && !m_busy;
            if (done_now && !m_hold_full && !data_wr) m_txc = 1;
            else if (txc_ack || (ctl_wr && ctl_wbyte[6])) m_txc = 0;
            if (ctl_wr) begin m_dbl = ctl_wbyte[1]; m_mpm = ctl_wbyte[0]; end
            if (load_now) begin
                m_busy = 1; m_sh = m_hold; m_n = len_of(char_width); m_tick = 0; m_idx = 0;
            end else if (m_busy) begin
                if (m_tick == BC - 1) begin
                    m_tick = 0;
                    if (done_now) m_busy = 0; else m_idx++;
                end else m_tick++;
            end
            if (load_now) m_hold_full = 0;
            else if (data_wr && !m_hold_full) begin
                m_hold_full = 1; m_hold = wr_byte & mask_of(char_width);
            end
            if (!rx_en) begin
                m_q.delete(); m_dor = 0;
            end else begin
                pop_now  = data_rd && m_q.size() > 0;
                lost_now = rx_valid && m_q.size() == 2 && !pop_now;
                if (pop_now) begin void'(m_q.pop_front()); m_dor = 0; end
                if (lost_now) m_dor = 1;
                else if (rx_valid)
                    m_q.push_back({rx_char & mask_of(char_width), rx_frame_err, rx_parity_err});
            end
        end
    end

    function automatic logic m_txd();
        if (!m_busy) return 1'b1;
        if (m_idx == 0) return 1'b0;
        if (m_idx <= m_n) return m_sh[m_idx-1];
        return 1'b1;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit ne = m_q.size() > 0;
        logic [9:0] h = ne ? m_q[0] : 10'h000;
        chk("R6 receive ready", {7'd0, ctl_byte[7]}, {7'd0, ne});
        chk("R8 transmit done", {7'd0, ctl_byte[6]}, {7'd0, m_txc});
        chk("R3 holding empty", {7'd0, ctl_byte[5]}, {7'd0, !m_hold_full});
        chk("R11 error bits", {6'd0, ctl_byte[4], ctl_byte[2]}, {6'd0, h[1], h[0]});
        chk("R10 overrun", {7'd0, ctl_byte[3]}, {7'd0, m_dor});
        chk("R9 control bits", {6'd0, ctl_byte[1:0]}, {6'd0, m_dbl, m_mpm});
        chk("R1 read data", rd_byte, h[9:2]);
        chk("R4 txd line", {7'd0, txd}, {7'd0, m_txd()});
        chk("R12 interrupts", {5'd0, irq_rx_ready, irq_hold_empty, irq_tx_done},
            {5'd0, ne && ie_rx_ready, !m_hold_full && ie_hold_empty, m_txc && ie_tx_done});
    endtask

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic wr(logic [7:0] b);
        data_wr = 1'b1; wr_byte = b; cyc(); data_wr = 1'b0;
    endtask

    task automatic rd();
        data_rd = 1'b1; cyc(); data_rd = 1'b0;
    endtask

    task automatic push(logic [7:0] b, logic f, logic p);
        rx_valid = 1'b1; rx_char = b; rx_frame_err = f; rx_parity_err = p;
        cyc(); rx_valid = 1'b0;
    endtask

    task automatic ctl(logic [7:0] b);
        ctl_wr = 1'b1; ctl_wbyte = b; cyc(); ctl_wr = 1'b0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired (all requirements)");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R9 reset status", ctl_byte, 8'h20);
        chk("R1 reset read data", rd_byte, 8'h00);

        // R4: transmitter disabled keeps the byte held
        ie_hold_empty = 1'b1; ie_tx_done = 1'b1; ie_rx_ready = 1'b1;
        wr(8'h3C);
        cyc(5);
        chk("R4 held while disabled", {7'd0, ctl_byte[5]}, 8'h00);
        chk("R12 hold irq low", {7'd0, irq_hold_empty}, 8'h00);
        tx_en = 1'b1;
        cyc(50);
        chk("R8 done after frame", {7'd0, ctl_byte[6]}, 8'h01);
        txc_ack = 1'b1; cyc(); txc_ack = 1'b0;
        chk("R8 cleared by ack", {7'd0, ctl_byte[6]}, 8'h00);

        // R3: back-to-back writes, the second is dropped
        wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
        cyc(120);

        // R2: 5-bit characters, upper bits not sent
        char_width = 2'd0;
        wr(8'hFF);
        cyc(40);
        char_width = 2'd1; wr(8'hA5); cyc(3); wr(8'h5A);
        cyc(80);
        char_width = 2'd3;

        // R8/R9: clear by control write, read-only bits unaffected
        ctl(8'h43);
        chk("R8 cleared by write", {7'd0, ctl_byte[6]}, 8'h00);
        chk("R9 control bits set", {6'd0, ctl_byte[1:0]}, 8'h03);
        ctl(8'hBC);
        chk("R9 read-only bits kept", ctl_byte, 8'h20);

        // R11/R2/R5: receive path
        rx_en = 1'b1; cyc();
        push(8'h5A, 1'b1, 1'b0);
        char_width = 2'd0;
        push(8'hFF, 1'b0, 1'b1);
        chk("R1 head data", rd_byte, 8'h5A);
        chk("R11 frame error of head", {7'd0, ctl_byte[4]}, 8'h01);
        rd();
        chk("R2 upper bits zero", rd_byte, 8'h1F);
        chk("R11 parity error of head", {7'd0, ctl_byte[2]}, 8'h01);
        rd();
        chk("R6 empty after reads", {7'd0, ctl_byte[7]}, 8'h00);
        rd();
        chk("R5 empty read no effect", rd_byte, 8'h00);
        char_width = 2'd3;

        // R10: overrun keeps the first two
        push(8'hA1, 1'b0, 1'b0); push(8'hA2, 1'b0, 1'b0); push(8'hA3, 1'b1, 1'b1);
        chk("R10 overrun set", {7'd0, ctl_byte[3]}, 8'h01);
        chk("R10 third char lost", rd_byte, 8'hA1);
        rd();
        chk("R10 overrun cleared by read", {7'd0, ctl_byte[3]}, 8'h00);
        chk("R5 second entry", rd_byte, 8'hA2);
        // push and read in the same cycle while full
        push(8'hB1, 1'b0, 1'b0);
        data_rd = 1'b1; push(8'hB2, 1'b0, 1'b0); data_rd = 1'b0;
        chk("R10 no overrun on push with read", {7'd0, ctl_byte[3]}, 8'h00);
        chk("R5 head after pop", rd_byte, 8'hB1);

        // R7: flush and ignore while disabled
        rx_en = 1'b0; cyc();
        chk("R7 flushed", {7'd0, ctl_byte[7]}, 8'h00);
        push(8'hC3, 1'b1, 1'b1);
        chk("R7 char ignored", {7'd0, ctl_byte[7]}, 8'h00);
        rx_en = 1'b1; cyc(2);
        chk("R7 still empty on re-enable", rd_byte, 8'h00);

        // R12: enables gate requests
        ie_rx_ready = 1'b0; push(8'h77, 1'b0, 1'b0);
        chk("R12 rx irq masked", {7'd0, irq_rx_ready}, 8'h00);
        ie_rx_ready = 1'b1; cyc();
        chk("R12 rx irq raised", {7'd0, irq_rx_ready}, 8'h01);
        cyc(5);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule